// File: doc/BRIEF.md
# Data Memory Bank Address Resolver

This block turns the short operand address of a 4-bit processor's data-memory instruction into a full 12-bit data-space address. The data space is split into sixteen banks of 256 nibbles. Only banks 0 and 1, which hold the RAM at 000H to 1FFH, are populated. Bank 15 holds the peripheral area from F80H to FFFH. The bank is chosen in one of two ways: from a bank-enable flag and a 4-bit bank register, or from the kind of instruction.

Each request carries an addressing class, an 8-bit operand, the current bank-enable flag and bank register, and a flag marking an 8-bit (paired-nibble) access. One clock later the block returns three results: the resolved address, the address of the upper nibble of a pair, and a flag saying whether the access is legal. The instruction sequencer uses the flag to block the memory write or to raise a fault. Requests may be issued in every cycle.

Top module: `dmem_bank_resolver`

## Requirements
- R1: A request sampled with `reqValid` high at a rising clock edge produces `rspValid` high after that edge, together with its results. A cycle without a request produces `rspValid` low after the next edge. After reset, `rspValid`, `accessOk`, `physAddr` and `physAddrHi` are all 0.
- R2: In direct class (`addrClass` = 0) with `bankEnable` = 0, the bank follows from the operand. Operands 00H to 7FH resolve to 000H plus the operand. Operands 80H to FFH resolve to F00H plus the operand. `bankSel` has no effect.
- R3: In direct class with `bankEnable` = 1, the address is `{bankSel, operand}`. The only accepted bank values are 0, 1 and 15. Any other value gives `accessOk` = 0.
- R4: In direct class, bank 15 is populated only from F80H upward. An operand below 80H that lands in bank 15 gives `accessOk` = 0.
- R5: In bit-manipulation class (`addrClass` = 1), the address is always in bank 15, whatever `bankEnable` and `bankSel` hold. Only operands B0H to BFH and F0H to FFH are accepted. All other operands give `accessOk` = 0.
- R6: In port class (`addrClass` = 2), the address is always in bank 15. Only operands C0H to FFH are accepted.
- R7: Class code 3 is reserved and always gives `accessOk` = 0.
- R8: When `pairAccess` = 1, an odd operand gives `accessOk` = 0. For an accepted even operand, `physAddr` is the even address and `physAddrHi` equals `physAddr` + 1. When `pairAccess` = 0, `physAddrHi` equals `physAddr`.
- R9: When `accessOk` = 0, both `physAddr` and `physAddrHi` are 000H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is presented this cycle |
| addrClass | input | 2 | 0 direct, 1 bit-manipulation, 2 port, 3 reserved |
| operand | input | 8 | Operand address from the instruction |
| bankEnable | input | 1 | 1 selects the bank from `bankSel` in direct class |
| bankSel | input | 4 | Bank register value |
| pairAccess | input | 1 | 1 marks an 8-bit paired-nibble access |
| rspValid | output | 1 | Results below belong to the request of the previous cycle |
| accessOk | output | 1 | The access is legal |
| physAddr | output | 12 | Resolved address (the even address for a pair) |
| physAddrHi | output | 12 | Address of the upper nibble of a pair |

## Verification
Two checks can reject the same request in one cycle: the pair-parity check and the bank or range check. The bench provokes this with an odd paired access to an unpopulated bank, and with an odd paired port access below C0H. It judges that `accessOk` drops and that both addresses read zero, with no partial address leaking through. A second overlap comes from back-to-back requests. A new request is captured on the same edge that presents the previous result, so the scoreboard queue must stay in order across an uninterrupted stream of accepted and rejected accesses.

// File: rtl/dmem_bank_pkg.sv
package dmem_bank_pkg;
  localparam int OFF_W  = 8;
  localparam int BANK_W = 4;
  localparam int ADDR_W = OFF_W + BANK_W;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef enum logic [1:0] {
    CLS_DIRECT = 2'd0,
    CLS_BIT    = 2'd1,
    CLS_PORT   = 2'd2,
    CLS_RSVD   = 2'd3
  } addr_class_e;

  typedef struct packed {
    logic              load;
    logic              okay;
    logic              pair;
    logic [BANK_W-1:0] bank;
  } resolve_strobe_t;
endpackage

// File: rtl/dmem_bank_ctrl.sv
module dmem_bank_ctrl
  import dmem_bank_pkg::*;
#(
  parameter int              RAM_BANKS   = 2,
  parameter logic [BANK_W-1:0] PERIPH_BANK = 4'hF,
  parameter logic [OFF_W-1:0]  PERIPH_OFF  = 8'h80,
  parameter logic [OFF_W-1:0]  PORT_OFF    = 8'hC0,
  parameter logic [OFF_W/2-1:0] BIT_GRP_A  = 4'hB,
  parameter logic [OFF_W/2-1:0] BIT_GRP_B  = 4'hF
) (
  input  logic              reqValid,
  input  logic [1:0]        addrClass,
  input  logic [OFF_W-1:0]  operand,
  input  logic              bankEnable,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              pairAccess,
  output resolve_strobe_t   strobe
);
  localparam int NIB_W = OFF_W / 2;

  logic             bankLegal [NUM_BANKS];
  logic [OFF_W-1:0] bankFloor [NUM_BANKS];

  // Bank population map: RAM banks are full, the peripheral bank starts at PERIPH_OFF.
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bankMap
    if (g < RAM_BANKS) begin : g_ram
      assign bankLegal[g] = 1'b1;
      assign bankFloor[g] = '0;
    end else if (g == int'(PERIPH_BANK)) begin : g_periph
      assign bankLegal[g] = 1'b1;
      assign bankFloor[g] = PERIPH_OFF;
    end else begin : g_absent
      assign bankLegal[g] = 1'b0;
      assign bankFloor[g] = '1;
    end
  end

  addr_class_e      cls;
  logic [BANK_W-1:0] bankPick;
  logic              rangeOk;
  logic              parityOk;

  assign cls = addr_class_e'(addrClass);

  always_comb begin
    bankPick = '0;
    rangeOk  = 1'b0;
    unique case (cls)
      CLS_DIRECT: begin
        if (bankEnable) begin
          bankPick = bankSel;
        end else if (operand >= PERIPH_OFF) begin
          bankPick = PERIPH_BANK;
        end else begin
          bankPick = '0;
        end
        rangeOk = bankLegal[bankPick] && (operand >= bankFloor[bankPick]);
      end
      CLS_BIT: begin
        bankPick = PERIPH_BANK;
        rangeOk  = (operand[OFF_W-1:NIB_W] == BIT_GRP_A) ||
                   (operand[OFF_W-1:NIB_W] == BIT_GRP_B);
      end
      CLS_PORT: begin
        bankPick = PERIPH_BANK;
        rangeOk  = (operand >= PORT_OFF);
      end
      default: begin
        bankPick = '0;
        rangeOk  = 1'b0;
      end
    endcase
  end

  assign parityOk = !(pairAccess && operand[0]);

  always_comb begin
    strobe.load = reqValid;
    strobe.okay = rangeOk && parityOk;
    strobe.pair = pairAccess;
    strobe.bank = bankPick;
  end

  // Immediate check: short-form classes never leave the peripheral bank
  always_comb begin
    if (reqValid && (cls == CLS_BIT || cls == CLS_PORT)) begin
      AST_SHORT_PINNED: assert (bankPick == PERIPH_BANK); // R5
    end
  end
endmodule

// File: rtl/dmem_bank_dpath.sv
module dmem_bank_dpath
  import dmem_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  resolve_strobe_t   strobe,
  input  logic [OFF_W-1:0]  operand,
  output logic              rspValid,
  output logic              accessOk,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] physAddrHi
);
  logic [ADDR_W-1:0] loAddr;
  logic [ADDR_W-1:0] hiAddr;

  assign loAddr = {strobe.bank, operand};
  assign hiAddr = {strobe.bank, operand[OFF_W-1:1], operand[0] | strobe.pair};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      accessOk   <= 1'b0;
      physAddr   <= '0;
      physAddrHi <= '0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        accessOk   <= strobe.okay;
        physAddr   <= strobe.okay ? loAddr : '0;
        physAddrHi <= strobe.okay ? hiAddr : '0;
      end
    end
  end

  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !accessOk) |-> (physAddr == '0 && physAddrHi == '0)); // R9
endmodule

// File: rtl/dmem_bank_resolver.sv
module dmem_bank_resolver
  import dmem_bank_pkg::*;
#(
  parameter int RAM_BANKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        addrClass,
  input  logic [OFF_W-1:0]  operand,
  input  logic              bankEnable,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              pairAccess,
  output logic              rspValid,
  output logic              accessOk,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] physAddrHi
);
  resolve_strobe_t strobe;

  dmem_bank_ctrl #(.RAM_BANKS(RAM_BANKS)) ctrl_i (
    .reqValid  (reqValid),
    .addrClass (addrClass),
    .operand   (operand),
    .bankEnable(bankEnable),
    .bankSel   (bankSel),
    .pairAccess(pairAccess),
    .strobe    (strobe)
  );

  dmem_bank_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operand   (operand),
    .rspValid  (rspValid),
    .accessOk  (accessOk),
    .physAddr  (physAddr),
    .physAddrHi(physAddrHi)
  );

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1

  AST_POPULATED: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && accessOk) |-> (physAddr < 12'h200 || physAddr >= 12'hF80)); // R4

  AST_LEGAL_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && addrClass == 2'd0 && bankEnable &&
     bankSel != 4'h0 && bankSel != 4'h1 && bankSel != 4'hF) |=> !accessOk); // R3

  AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && addrClass == 2'd2) |=> (!accessOk || physAddr[11:6] == 6'h3F)); // R6

  AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && addrClass == 2'd3) |=> !accessOk); // R7

  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pairAccess) |=>
      (!accessOk || (physAddr[0] == 1'b0 && physAddrHi == physAddr + 12'd1))); // R8
endmodule

// File: tb/dmem_bank_resolver_tb.sv
`timescale 1ns/1ps
module dmem_bank_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  addrClass = 2'd0;
  logic [7:0]  operand = 8'h00;
  logic        bankEnable = 1'b0;
  logic [3:0]  bankSel = 4'h0;
  logic        pairAccess = 1'b0;
  logic        rspValid;
  logic        accessOk;
  logic [11:0] physAddr;
  logic [11:0] physAddrHi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;

  typedef struct {
    logic        ok;
    logic [11:0] lo;
    logic [11:0] hi;
    string       tag;
  } exp_t;

  exp_t sbQ[$];

  always #2 clk = ~clk;

  dmem_bank_resolver dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .addrClass(addrClass),
    .operand(operand), .bankEnable(bankEnable), .bankSel(bankSel),
    .pairAccess(pairAccess), .rspValid(rspValid), .accessOk(accessOk),
    .physAddr(physAddr), .physAddrHi(physAddrHi)
  );

  task automatic send(input logic [1:0] c, input logic [7:0] op, input logic be,
                      input logic [3:0] sel, input logic pr, input logic eOk,
                      input logic [11:0] eLo, input logic [11:0] eHi, input string tag);
    exp_t e;
    @(negedge clk);
    e.ok = eOk; e.lo = eLo; e.hi = eHi; e.tag = tag;
    sbQ.push_back(e);
    reqValid = 1'b1; addrClass = c; operand = op;
    bankEnable = be; bankSel = sel; pairAccess = pr;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: compares each response with the head of the scoreboard
  always @(negedge clk) begin
    if (monOn && rspValid) begin
      checks++;
      if (sbQ.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected response: actual rspValid=1 expected rspValid=0");
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        if (accessOk !== e.ok || physAddr !== e.lo || physAddrHi !== e.hi) begin
          fails++;
          $display("FAIL %s: actual ok=%0b addr=%03h hi=%03h expected ok=%0b addr=%03h hi=%03h",
                   e.tag, accessOk, physAddr, physAddrHi, e.ok, e.lo, e.hi);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || accessOk !== 1'b0 || physAddr !== 12'h0 || physAddrHi !== 12'h0) begin
      fails++;
      $display("FAIL R1 reset: actual v=%0b ok=%0b addr=%03h hi=%03h expected all 0",
               rspValid, accessOk, physAddr, physAddrHi);
    end
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);

    // R2: bank from operand when banking disabled; bankSel ignored
    send(2'd0, 8'h3C, 1'b0, 4'h7, 1'b0, 1'b1, 12'h03C, 12'h03C, "R2 low 3C");
    send(2'd0, 8'h7F, 1'b0, 4'h1, 1'b0, 1'b1, 12'h07F, 12'h07F, "R2 edge 7F");
    send(2'd0, 8'h80, 1'b0, 4'h0, 1'b0, 1'b1, 12'hF80, 12'hF80, "R2 edge 80");
    send(2'd0, 8'hFF, 1'b0, 4'h2, 1'b0, 1'b1, 12'hFFF, 12'hFFF, "R2 top FF");
    // R3: bank register
    send(2'd0, 8'h20, 1'b1, 4'h1, 1'b0, 1'b1, 12'h120, 12'h120, "R3 bank1");
    send(2'd0, 8'h90, 1'b1, 4'h0, 1'b0, 1'b1, 12'h090, 12'h090, "R3 bank0 high");
    send(2'd0, 8'hA4, 1'b1, 4'hF, 1'b0, 1'b1, 12'hFA4, 12'hFA4, "R3 bank15");
    send(2'd0, 8'h10, 1'b1, 4'h2, 1'b0, 1'b0, 12'h000, 12'h000, "R3 R9 bank2 illegal");
    send(2'd0, 8'h90, 1'b1, 4'hE, 1'b0, 1'b0, 12'h000, 12'h000, "R3 R9 bank14 illegal");
    // R4: hole below peripheral area
    send(2'd0, 8'h7F, 1'b1, 4'hF, 1'b0, 1'b0, 12'h000, 12'h000, "R4 F7F absent");
    send(2'd0, 8'h00, 1'b1, 4'hF, 1'b0, 1'b0, 12'h000, 12'h000, "R4 F00 absent");
    // R5: bit-manipulation class
    send(2'd1, 8'hB0, 1'b1, 4'h1, 1'b0, 1'b1, 12'hFB0, 12'hFB0, "R5 B0");
    send(2'd1, 8'hBF, 1'b0, 4'h0, 1'b0, 1'b1, 12'hFBF, 12'hFBF, "R5 BF");
    send(2'd1, 8'hF5, 1'b1, 4'h3, 1'b0, 1'b1, 12'hFF5, 12'hFF5, "R5 F5");
    send(2'd1, 8'hC0, 1'b0, 4'h0, 1'b0, 1'b0, 12'h000, 12'h000, "R5 C0 outside");
    send(2'd1, 8'hAF, 1'b0, 4'h0, 1'b0, 1'b0, 12'h000, 12'h000, "R5 AF outside");
    // R6: port class
    send(2'd2, 8'hC0, 1'b1, 4'h0, 1'b0, 1'b1, 12'hFC0, 12'hFC0, "R6 C0");
    send(2'd2, 8'hFF, 1'b0, 4'h1, 1'b0, 1'b1, 12'hFFF, 12'hFFF, "R6 FF");
    send(2'd2, 8'hBF, 1'b0, 4'h0, 1'b0, 1'b0, 12'h000, 12'h000, "R6 BF outside");
    // R7: reserved class
    send(2'd3, 8'h10, 1'b0, 4'h0, 1'b0, 1'b0, 12'h000, 12'h000, "R7 reserved");
    send(2'd3, 8'hFC, 1'b1, 4'hF, 1'b0, 1'b0, 12'h000, 12'h000, "R7 reserved high");
    // R8: paired access
    send(2'd0, 8'h24, 1'b0, 4'h0, 1'b1, 1'b1, 12'h024, 12'h025, "R8 even pair");
    send(2'd0, 8'h25, 1'b0, 4'h0, 1'b1, 1'b0, 12'h000, 12'h000, "R8 odd pair");
    send(2'd2, 8'hC6, 1'b0, 4'h0, 1'b1, 1'b1, 12'hFC6, 12'hFC7, "R8 port pair");
    send(2'd0, 8'hFE, 1'b1, 4'h1, 1'b1, 1'b1, 12'h1FE, 12'h1FF, "R8 bank1 pair");
    // Overlap of parity and range rejection
    send(2'd0, 8'h33, 1'b1, 4'h5, 1'b1, 1'b0, 12'h000, 12'h000, "R8 R9 odd in bank5");
    send(2'd2, 8'hA1, 1'b0, 4'h0, 1'b1, 1'b0, 12'h000, 12'h000, "R8 R9 odd port low");
    idle();
    // R1: no request leaves rspValid low
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle: actual rspValid=%0b expected 0", rspValid);
    end
    repeat (2) @(negedge clk);
    checks++;
    if (sbQ.size() != 0) begin
      fails++;
      $display("FAIL R1 missing responses: actual pending=%0d expected 0", sbQ.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule